// File: doc/BRIEF.md
# Software-Filled Translation Buffer with First-Store Detection

This block is a set-associative address translation buffer. Hardware never fills it. Software builds each entry in two staging registers. The tag register holds a virtual page number. The attribute register holds a physical page number together with protection, page-size, cacheable, modified, shared and valid flags. A single load strobe then copies both staging registers into one set, in the way that a software-visible victim-way register names. Hardware picks no victim of its own.

Each lookup presents a virtual address, a store/load flag and a user/privileged flag. One cycle later the block reports exactly one outcome: a clean translation, a miss, a protection violation, or a first-store fault. A first-store fault means a permitted store hit a page whose modified flag is still clear. The block does not set that flag itself. It reports the fault and writes the hitting way back into the victim-way register. Software can then rewrite that same entry with the flag set.

Top module: `tlbsw_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, the victim-way register reads 0, and all result outputs are 0.
- R2: A load strobe copies the staged tag and attribute words into the way held in the victim-way register. The set is chosen by tag bits [SPAN+IDX_W-1:SPAN]. A lookup presented in the cycle right after the strobe already sees the new entry. Each lookup result appears on the outputs one cycle after `lk_valid`.
- R3: The attribute word is laid out as follows: bit 0 valid, bit 1 shared, bit 2 modified, bit 3 cacheable, bit 4 large page, bits 6:5 protection, and bits above 6 the physical page number. On a clean translation, `res_cacheable` and `res_shared` return the stored flags.
- R4: For a small page (bit 4 = 0), every virtual page number bit takes part in the compare, so an address that differs in bit PG_SHIFT misses.
- R5: For a large page (bit 4 = 1), virtual address bits [LG_SHIFT-1:PG_SHIFT] are left out of the compare. The same bits replace the low SPAN bits of the returned physical page number.
- R6: A lookup misses when no entry in the indexed set has the valid bit set and a matching tag. An entry loaded with valid = 0 never matches.
- R7: Protection code 00 allows privileged loads only. Code 01 allows privileged loads and stores. Code 10 allows loads in either mode. Code 11 allows everything. A hit that is not allowed reports `res_prot_fault`.
- R8: A permitted store that hits an entry with modified = 0 reports `res_first_write`. A load that hits such an entry reports a clean hit.
- R9: A first-store fault writes the hitting way into the victim-way register, and this wins over a software write to that register in the same cycle. Otherwise the register changes only when `ctl_we` is high.
- R10: Exactly one of hit, miss, protection fault and first-store fault is set for every lookup, with priority miss > protection > first-store. Without a lookup, all result outputs are 0. `res_way` and `res_ppn` are 0 when they do not apply.
- R11: The set index is virtual address bits [LG_SHIFT+IDX_W-1:LG_SHIFT]. Entries in different ways or different sets coexist. If two ways of a set both match, the lowest-numbered way wins.
- R12: A load strobe uses the staging and victim-way values from before any register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_hi_we | input | 1 | Write staged tag |
| stg_hi_vpn | input | VA_W-PG_SHIFT | Staged virtual page number |
| stg_lo_we | input | 1 | Write staged attribute word |
| stg_lo_data | input | PA_W-PG_SHIFT+7 | Staged attribute word (layout in R3) |
| ctl_we | input | 1 | Write victim-way register |
| ctl_way_wdata | input | WAY_W | New victim way |
| load_cmd | input | 1 | Copy staged entry into the buffer |
| ctl_way | output | WAY_W | Current victim-way register |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_write | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user mode, 0 = privileged |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Clean translation |
| res_miss | output | 1 | No matching valid entry |
| res_prot_fault | output | 1 | Access not permitted |
| res_first_write | output | 1 | Store to an unmodified page |
| res_way | output | WAY_W | Way that matched |
| res_ppn | output | PA_W-PG_SHIFT | Physical page number on a clean hit |
| res_cacheable | output | 1 | Cacheable flag on a clean hit |
| res_shared | output | 1 | Shared flag on a clean hit |

## Verification
An empty buffer is probed first. Entries are then placed in chosen ways and probed with the exact page, with a neighbour page one small-page step away, and with a different set. This separates a tag compare that is too wide or too narrow from a wrong set index. Large-page entries are probed across all four small-page offsets inside the large page. This shows both the masked compare and the physical number splice. Every protection code is crossed with user/privileged and load/store. Modified and unmodified pages are hit with loads and stores, which distinguishes the fault priority and the victim-way write-back. Load strobes issued together with staging or victim writes expose any forwarding of new values.

// File: rtl/tlbsw_pkg.sv
package tlbsw_pkg;
   localparam int ATTR_V  = 0;
   localparam int ATTR_SH = 1;
   localparam int ATTR_D  = 2;
   localparam int ATTR_C  = 3;
   localparam int ATTR_SZ = 4;
   localparam int ATTR_PR = 5;
   localparam int ATTR_W  = 7;

   typedef enum logic [1:0] {
      PROT_PRIV_RO = 2'b00,
      PROT_PRIV_RW = 2'b01,
      PROT_ANY_RO  = 2'b10,
      PROT_ANY_RW  = 2'b11
   } prot_e;

   function automatic logic prot_allows(input logic [1:0] pr, input logic user, input logic wr);
      return (!user || pr[1]) && (!wr || pr[0]);
   endfunction
endpackage

// File: rtl/tlbsw_stage.sv
module tlbsw_stage #(
   parameter int VPN_W = 22,
   parameter int LO_W  = 26,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_we,
   input  logic [VPN_W-1:0] hi_d,
   input  logic             lo_we,
   input  logic [LO_W-1:0]  lo_d,
   input  logic             way_we,
   input  logic [WAY_W-1:0] way_d,
   input  logic             fw_set,
   input  logic [WAY_W-1:0] fw_way,
   output logic [VPN_W-1:0] hi_q,
   output logic [LO_W-1:0]  lo_q,
   output logic [WAY_W-1:0] way_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         way_q <= '0;
      end else begin
         if (hi_we) hi_q <= hi_d;
         if (lo_we) lo_q <= lo_d;
         if (fw_set)      way_q <= fw_way;
         else if (way_we) way_q <= way_d;
      end
   end
endmodule

// File: rtl/tlbsw_way.sv
module tlbsw_way #(
   parameter int VPN_W = 22,
   parameter int LO_W  = 26,
   parameter int NSETS = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [VPN_W-1:0] wvpn,
   input  logic [LO_W-1:0]  wlo,
   input  logic [IDX_W-1:0] ridx,
   output logic [VPN_W-1:0] rvpn,
   output logic [LO_W-1:0]  rlo
);
   logic [VPN_W-1:0] vpn_q [NSETS];
   logic [LO_W-1:0]  lo_q  [NSETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) begin
            vpn_q[s] <= '0;
            lo_q[s]  <= '0;
         end
      end else if (we) begin
         vpn_q[widx] <= wvpn;
         lo_q[widx]  <= wlo;
      end
   end

   assign rvpn = vpn_q[ridx];
   assign rlo  = lo_q[ridx];
endmodule

// File: rtl/tlbsw_match.sv
module tlbsw_match #(
   parameter int VPN_W = 22,
   parameter int LO_W  = 26,
   parameter int SPAN  = 2
) (
   input  logic [VPN_W-1:0] va_vpn,
   input  logic [VPN_W-1:0] ent_vpn,
   input  logic [LO_W-1:0]  ent_lo,
   output logic             match
);
   import tlbsw_pkg::*;
   localparam logic [VPN_W-1:0] LARGE_MASK = {{(VPN_W-SPAN){1'b1}}, {SPAN{1'b0}}};

   logic [VPN_W-1:0] mask;
   assign mask  = ent_lo[ATTR_SZ] ? LARGE_MASK : '1;
   assign match = ent_lo[ATTR_V] && (((va_vpn ^ ent_vpn) & mask) == '0);
endmodule

// File: rtl/tlbsw_top.sv
module tlbsw_top #(
   parameter int NWAYS    = 4,
   parameter int NSETS    = 16,
   parameter int VA_W     = 32,
   parameter int PA_W     = 29,
   parameter int PG_SHIFT = 10,
   parameter int LG_SHIFT = 12,
   parameter int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        stg_hi_we,
   input  logic [VA_W-PG_SHIFT-1:0]    stg_hi_vpn,
   input  logic                        stg_lo_we,
   input  logic [PA_W-PG_SHIFT+6:0]    stg_lo_data,
   input  logic                        ctl_we,
   input  logic [WAY_W-1:0]            ctl_way_wdata,
   input  logic                        load_cmd,
   output logic [WAY_W-1:0]            ctl_way,
   input  logic                        lk_valid,
   input  logic [VA_W-1:0]             lk_vaddr,
   input  logic                        lk_write,
   input  logic                        lk_user,
   output logic                        res_valid,
   output logic                        res_hit,
   output logic                        res_miss,
   output logic                        res_prot_fault,
   output logic                        res_first_write,
   output logic [WAY_W-1:0]            res_way,
   output logic [PA_W-PG_SHIFT-1:0]    res_ppn,
   output logic                        res_cacheable,
   output logic                        res_shared
);
   import tlbsw_pkg::*;

   localparam int VPN_W = VA_W - PG_SHIFT;
   localparam int PPN_W = PA_W - PG_SHIFT;
   localparam int LO_W  = PPN_W + ATTR_W;
   localparam int SPAN  = LG_SHIFT - PG_SHIFT;
   localparam int IDX_W = $clog2(NSETS);

   if (SPAN < 1) begin : g_bad_span
      $error("LG_SHIFT must exceed PG_SHIFT");
   end
   if (NSETS < 2 || (1 << IDX_W) != NSETS) begin : g_bad_sets
      $error("NSETS must be a power of two of at least 2");
   end
   if (SPAN + IDX_W > VPN_W || PPN_W <= SPAN) begin : g_bad_width
      $error("address widths too small for set index or large-page splice");
   end
   if (NWAYS < 1 || (NWAYS > 1 && (1 << WAY_W) < NWAYS)) begin : g_bad_ways
      $error("WAY_W cannot encode NWAYS");
   end

   logic [VPN_W-1:0] hi_q;
   logic [LO_W-1:0]  lo_q;
   logic [WAY_W-1:0] way_q;
   logic             fw_set;
   logic [WAY_W-1:0] sel;

   tlbsw_stage #(.VPN_W(VPN_W), .LO_W(LO_W), .WAY_W(WAY_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .hi_we(stg_hi_we), .hi_d(stg_hi_vpn),
      .lo_we(stg_lo_we), .lo_d(stg_lo_data),
      .way_we(ctl_we), .way_d(ctl_way_wdata),
      .fw_set(fw_set), .fw_way(sel),
      .hi_q(hi_q), .lo_q(lo_q), .way_q(way_q)
   );
   assign ctl_way = way_q;

   logic [VPN_W-1:0] va_vpn;
   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] ld_idx;
   assign va_vpn = lk_vaddr[VA_W-1:PG_SHIFT];
   assign lk_idx = lk_vaddr[LG_SHIFT +: IDX_W];
   assign ld_idx = hi_q[SPAN +: IDX_W];

   logic [VPN_W-1:0] rvpn [NWAYS];
   logic [LO_W-1:0]  rlo  [NWAYS];
   logic [NWAYS-1:0] m;

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      logic wr_this;
      assign wr_this = load_cmd && (way_q == WAY_W'(w));
      tlbsw_way #(.VPN_W(VPN_W), .LO_W(LO_W), .NSETS(NSETS), .IDX_W(IDX_W)) u_way (
         .clk(clk), .rst_n(rst_n),
         .we(wr_this), .widx(ld_idx), .wvpn(hi_q), .wlo(lo_q),
         .ridx(lk_idx), .rvpn(rvpn[w]), .rlo(rlo[w])
      );
      tlbsw_match #(.VPN_W(VPN_W), .LO_W(LO_W), .SPAN(SPAN)) u_match (
         .va_vpn(va_vpn), .ent_vpn(rvpn[w]), .ent_lo(rlo[w]), .match(m[w])
      );
   end

   if (NWAYS == 1) begin : g_sel_single
      assign sel = '0;
   end else begin : g_sel_prio
      always_comb begin
         sel = '0;
         for (int w = NWAYS - 1; w >= 0; w--) begin
            if (m[w]) sel = WAY_W'(w);
         end
      end
   end

   logic [LO_W-1:0]  sel_lo;
   logic [PPN_W-1:0] ppn_ent;
   logic [PPN_W-1:0] ppn_eff;
   logic             miss, allowed, prot, fw, hit;

   assign sel_lo  = rlo[sel];
   assign ppn_ent = sel_lo[LO_W-1 -: PPN_W];
   assign ppn_eff = sel_lo[ATTR_SZ] ? {ppn_ent[PPN_W-1:SPAN], lk_vaddr[LG_SHIFT-1:PG_SHIFT]}
                                    : ppn_ent;
   assign miss    = (m == '0);
   assign allowed = prot_allows(sel_lo[ATTR_PR +: 2], lk_user, lk_write);
   assign prot    = !miss && !allowed;
   assign fw      = !miss && allowed && lk_write && !sel_lo[ATTR_D];
   assign hit     = !miss && allowed && !fw;
   assign fw_set  = lk_valid && fw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid       <= 1'b0;
         res_hit         <= 1'b0;
         res_miss        <= 1'b0;
         res_prot_fault  <= 1'b0;
         res_first_write <= 1'b0;
         res_way         <= '0;
         res_ppn         <= '0;
         res_cacheable   <= 1'b0;
         res_shared      <= 1'b0;
      end else begin
         res_valid       <= lk_valid;
         res_hit         <= lk_valid && hit;
         res_miss        <= lk_valid && miss;
         res_prot_fault  <= lk_valid && prot;
         res_first_write <= lk_valid && fw;
         res_way         <= (lk_valid && !miss) ? sel : '0;
         res_ppn         <= (lk_valid && hit) ? ppn_eff : '0;
         res_cacheable   <= lk_valid && hit && sel_lo[ATTR_C];
         res_shared      <= lk_valid && hit && sel_lo[ATTR_SH];
      end
   end
endmodule

// File: rtl/tlbsw_chk.sv
module tlbsw_chk #(
   parameter int WAY_W = 2,
   parameter int PPN_W = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_write,
   input logic             ctl_we,
   input logic [WAY_W-1:0] ctl_way,
   input logic             res_valid,
   input logic             res_hit,
   input logic             res_miss,
   input logic             res_prot_fault,
   input logic             res_first_write,
   input logic [WAY_W-1:0] res_way,
   input logic [PPN_W-1:0] res_ppn
);
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !(res_valid || res_hit || res_miss || res_prot_fault || res_first_write));

   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($countones({res_hit, res_miss, res_prot_fault, res_first_write}) == 1));

   p_load_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_write) |=> !res_first_write);

   p_fault_way_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_first_write |-> (ctl_way == res_way));

   p_way_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> ($stable(ctl_way) || res_first_write));

   p_miss_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss |-> (res_ppn == '0 && res_way == '0));
endmodule

bind tlbsw_top tlbsw_chk #(.WAY_W(WAY_W), .PPN_W(PA_W - PG_SHIFT)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
   .ctl_we(ctl_we), .ctl_way(ctl_way), .res_valid(res_valid), .res_hit(res_hit),
   .res_miss(res_miss), .res_prot_fault(res_prot_fault),
   .res_first_write(res_first_write), .res_way(res_way), .res_ppn(res_ppn)
);

// File: tb/tlbsw_top_bench.sv
module tlbsw_top_bench;
   localparam int NW = 4;
   localparam int NS = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        d_hi_we = 0, d_lo_we = 0, d_ctl_we = 0, d_load = 0;
   logic [21:0] d_hi = '0;
   logic [25:0] d_lo = '0;
   logic [1:0]  d_ctl = '0;
   logic        d_lk = 0, d_wr = 0, d_user = 0;
   logic [31:0] d_va = '0;

   logic [1:0]  ctl_way, res_way;
   logic        res_valid, res_hit, res_miss, res_prot_fault, res_first_write;
   logic        res_cacheable, res_shared;
   logic [18:0] res_ppn;

   tlbsw_top u_tlbsw_top (
      .clk(clk), .rst_n(rst_n),
      .stg_hi_we(d_hi_we), .stg_hi_vpn(d_hi), .stg_lo_we(d_lo_we), .stg_lo_data(d_lo),
      .ctl_we(d_ctl_we), .ctl_way_wdata(d_ctl), .load_cmd(d_load), .ctl_way(ctl_way),
      .lk_valid(d_lk), .lk_vaddr(d_va), .lk_write(d_wr), .lk_user(d_user),
      .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
      .res_prot_fault(res_prot_fault), .res_first_write(res_first_write),
      .res_way(res_way), .res_ppn(res_ppn), .res_cacheable(res_cacheable),
      .res_shared(res_shared)
   );

   always #10 clk = ~clk;

   int    vectors = 0;
   int    errors = 0;
   string cur_req = "R1";

   // reference state
   logic [21:0] m_vpn [NW][NS];
   logic [25:0] m_ent [NW][NS];
   logic [21:0] m_hi;
   logic [25:0] m_lo;
   int          m_way;
   logic        e_valid, e_hit, e_miss, e_prot, e_fw, e_c, e_sh;
   int          e_way;
   logic [18:0] e_ppn;

   function automatic logic [25:0] mk(input logic [18:0] ppn, input logic [1:0] pr,
                                      input logic sz, input logic c, input logic d,
                                      input logic sh, input logic v);
      return {ppn, pr, sz, c, d, sh, v};
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin m_vpn[w][s] = '0; m_ent[w][s] = '0; end
         m_hi = '0; m_lo = '0; m_way = 0;
         e_valid = 0; e_hit = 0; e_miss = 0; e_prot = 0; e_fw = 0; e_c = 0; e_sh = 0;
         e_way = 0; e_ppn = '0;
      end else begin
         int hw = -1;
         int idx = int'(d_va[15:12]);
         logic [21:0] vv = d_va[31:10];
         logic [25:0] ent = '0;
         logic ok;
         for (int w = 0; w < NW; w++) begin
            logic [25:0] c = m_ent[w][idx];
            logic [21:0] msk = c[4] ? 22'h3FFFFC : 22'h3FFFFF;
            if (hw < 0 && c[0] && (((vv ^ m_vpn[w][idx]) & msk) == 0)) hw = w;
         end
         if (hw >= 0) ent = m_ent[hw][idx];
         ok = (!d_user || ent[6]) && (!d_wr || ent[5]);
         e_valid = d_lk;
         e_miss  = d_lk && hw < 0;
         e_prot  = d_lk && hw >= 0 && !ok;
         e_fw    = d_lk && hw >= 0 && ok && d_wr && !ent[2];
         e_hit   = d_lk && hw >= 0 && ok && !e_fw;
         e_way   = (d_lk && hw >= 0) ? hw : 0;
         e_ppn   = e_hit ? (ent[4] ? {ent[25:9], d_va[11:10]} : ent[25:7]) : '0;
         e_c     = e_hit && ent[3];
         e_sh    = e_hit && ent[1];
         if (d_load) begin
            m_vpn[m_way][int'(m_hi[5:2])] = m_hi;
            m_ent[m_way][int'(m_hi[5:2])] = m_lo;
         end
         if (e_fw) m_way = hw;
         else if (d_ctl_we) m_way = int'(d_ctl);
         if (d_hi_we) m_hi = d_hi;
         if (d_lo_we) m_lo = d_lo;
      end
   endtask

   task automatic cmp1(input string f, input longint act, input longint exp);
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, f, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      vectors++;
      cmp1("ctl_way", ctl_way, m_way);
      cmp1("valid", res_valid, e_valid);
      cmp1("hit", res_hit, e_hit);
      cmp1("miss", res_miss, e_miss);
      cmp1("prot", res_prot_fault, e_prot);
      cmp1("first_write", res_first_write, e_fw);
      cmp1("way", res_way, e_way);
      cmp1("ppn", res_ppn, e_ppn);
      cmp1("cacheable", res_cacheable, e_c);
      cmp1("shared", res_shared, e_sh);
      d_hi_we = 0; d_lo_we = 0; d_ctl_we = 0; d_load = 0; d_lk = 0; d_wr = 0; d_user = 0;
   endtask

   task automatic put(input int way, input logic [21:0] vpn, input logic [25:0] lo);
      d_ctl_we = 1; d_ctl = 2'(way); d_hi_we = 1; d_hi = vpn; d_lo_we = 1; d_lo = lo;
      tick();
      d_load = 1;
      tick();
   endtask

   task automatic look(input logic [31:0] va, input logic wr, input logic user);
      d_lk = 1; d_va = va; d_wr = wr; d_user = user;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      // R1: reset state, empty buffer misses
      cur_req = "R1";
      repeat (3) tick();
      rst_n = 1;
      tick();
      look(32'h1234_5400, 0, 0);
      look(32'hFFFF_FC00, 1, 1);

      // R2 / R3: load then look up in the very next cycle
      cur_req = "R2";
      put(2, 22'h01234, mk(19'h5A5A5, 2'b11, 0, 1, 1, 1, 1));
      look({22'h01234, 10'h155}, 0, 1);
      cur_req = "R3";
      look({22'h01234, 10'h0}, 1, 0);

      // R4: small page, neighbour page differs in bit PG_SHIFT
      cur_req = "R4";
      look({22'h01235, 10'h0}, 0, 0);

      // R5: large page, all four small offsets inside
      cur_req = "R5";
      put(1, 22'h2A3C0, mk(19'h7FFFF, 2'b11, 1, 0, 1, 0, 1));
      for (int k = 0; k < 4; k++) look({22'h2A3C0 | 22'(k), 10'h3}, 0, 0);
      look({22'h2A3C4, 10'h0}, 0, 0);

      // R6: invalid entry never matches
      cur_req = "R6";
      put(0, 22'h00440, mk(19'h00111, 2'b11, 0, 0, 1, 0, 0));
      look({22'h00440, 10'h0}, 0, 0);

      // R7: every protection code against mode and access
      cur_req = "R7";
      for (int p = 0; p < 4; p++) begin
         put(p, 22'h10000 | 22'(p << 2), mk(19'(p + 8), 2'(p), 0, 1, 1, 0, 1));
         for (int u = 0; u < 2; u++)
            for (int w = 0; w < 2; w++)
               look({22'h10000 | 22'(p << 2), 10'h0}, w[0], u[0]);
      end

      // R8: clean page, load hits, store faults; protection beats first-store
      cur_req = "R8";
      put(3, 22'h03330, mk(19'h0ABCD, 2'b11, 0, 0, 0, 1, 1));
      look({22'h03330, 10'h0}, 0, 1);
      d_ctl_we = 1; d_ctl = 2'd0; tick();
      look({22'h03330, 10'h0}, 1, 1);
      put(1, 22'h03334, mk(19'h0ABCE, 2'b10, 0, 0, 0, 0, 1));
      look({22'h03334, 10'h0}, 1, 0);

      // R9: first-store wins over victim write in same cycle
      cur_req = "R9";
      d_ctl_we = 1; d_ctl = 2'd1; tick();
      d_ctl_we = 1; d_ctl = 2'd2;
      look({22'h03330, 10'h0}, 1, 0);
      tick();

      // R10: miss beats everything, idle cycles quiet
      cur_req = "R10";
      look({22'h3FFFF, 10'h0}, 1, 1);
      tick();

      // R11: duplicates pick lowest way; other sets coexist
      cur_req = "R11";
      put(3, 22'h05550, mk(19'h00033, 2'b11, 0, 0, 1, 0, 1));
      put(1, 22'h05550, mk(19'h00011, 2'b11, 0, 0, 1, 0, 1));
      put(1, 22'h05554, mk(19'h00044, 2'b11, 0, 0, 1, 0, 1));
      look({22'h05550, 10'h0}, 0, 0);
      look({22'h05554, 10'h0}, 0, 0);

      // R12: load uses pre-write staging and victim values
      cur_req = "R12";
      put(0, 22'h06660, mk(19'h00066, 2'b11, 0, 0, 1, 0, 1));
      d_hi_we = 1; d_hi = 22'h06664; d_lo_we = 1; d_lo = mk(19'h00077, 2'b11, 0, 0, 1, 0, 1);
      d_ctl_we = 1; d_ctl = 2'd3; d_load = 1;
      tick();
      look({22'h06660, 10'h0}, 0, 0);
      look({22'h06664, 10'h0}, 0, 0);
      tick();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule